// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block is the transmit half of a UART. A host writes a line-format byte into a configuration register through a small register bus. That byte sets the character length, the stop period, the parity mode and a break override. The host can read the byte back at any time. Writing a data byte to the holding offset starts one serial frame on a single output line. The line idles high. The frame is a low start bit, then the data bits with the least significant bit first, then an optional parity bit, then a high stop period.

All bit timing comes from an external one-cycle `tick` strobe that pulses sixteen times per bit period, so every bit spans sixteen ticks. The length of the stop period depends on two settings together: the stop flag and the character length. `busy` tells the host when a new byte may be written.

Top module: `sertx_top`

## Requirements
- R1: Configuration bits [1:0] choose the character length: 00 gives 5 data bits, 01 gives 6, 10 gives 7 and 11 gives 8. A frame begins with a low start bit lasting 16 ticks. The data bits follow, least significant first, 16 ticks each.
- R2: With configuration bit 2 clear, the stop period is high for exactly 16 ticks.
- R3: With bit 2 set and a 5-bit length, the stop period is high for 24 ticks.
- R4: With bit 2 set and a 6-, 7- or 8-bit length, the stop period is high for 32 ticks.
- R5: With bit 3 set and bit 5 clear, a 16-tick parity bit follows the data. When bit 4 is 1, the parity bit makes the count of ones over data plus parity even. When bit 4 is 0, it makes that count odd.
- R6: With bits 3 and 5 both set, the parity bit is the constant inverse of bit 4.
- R7: While bit 6 (break) is 1, `txd` is held low. The frame in progress keeps its timing, and `busy` stays high.
- R8: A read at offset 3 returns all 8 bits last written there, including bit 7. A read at any other offset, or with `rd_en` low, returns 0.
- R9: A write at offset 0 while idle and with bit 7 clear loads the byte. `busy` rises on the next cycle and falls on the tick that ends the stop period. A write at offset 0 is ignored while `busy` is high or while bit 7 is set.
- R10: After reset the configuration byte is 0, `txd` is 1 and `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 3 | Register offset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data |
| tick | input | 1 | Timing strobe at 16 times the bit rate |
| txd | output | 1 | Serial output |
| busy | output | 1 | Frame in progress |

## Verification
Two cases are hard to reach from the ports: a data write that lands in the middle of a frame, and a break that is raised and then dropped inside a frame. Both must leave the frame length unchanged. The bench starts an all-zero frame and writes 0xFF partway through it. It then counts the high ticks until `busy` falls; only the 16 stop ticks should be high. For the break case, an all-ones frame is interrupted by a break for 20 ticks. The bench then checks that the total tick count still equals one 8N1 frame.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    localparam int TICKS_PER_BIT = 16;
    localparam int CNT_W         = $clog2(2 * TICKS_PER_BIT);
    localparam int BYTE_W        = 8;
    localparam int IDX_W         = $clog2(BYTE_W);

    // Field order follows the configuration byte, bit 7 down to bit 0.
    typedef struct packed {
        logic       dlab;
        logic       brk;
        logic       stick;
        logic       even;
        logic       par_en;
        logic       long_stop;
        logic [1:0] wlen;
    } line_cfg_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } tx_state_t;

    function automatic logic [IDX_W-1:0] last_bit_index(input logic [1:0] wlen);
        return IDX_W'(4) + IDX_W'(wlen);
    endfunction

    function automatic logic [CNT_W-1:0] stop_last_count(input line_cfg_t c);
        if (!c.long_stop)
            return CNT_W'(TICKS_PER_BIT - 1);
        else if (c.wlen == 2'b00)
            return CNT_W'((TICKS_PER_BIT * 3) / 2 - 1);
        else
            return CNT_W'(2 * TICKS_PER_BIT - 1);
    endfunction

    function automatic logic parity_value(input line_cfg_t c, input logic [BYTE_W-1:0] d);
        logic [BYTE_W-1:0] mask;
        logic              ones;
        mask = {BYTE_W{1'b1}} >> (2'd3 - c.wlen);
        ones = ^(d & mask);
        if (c.stick)
            return ~c.even;
        return c.even ? ones : ~ones;
    endfunction

endpackage

// File: rtl/sertx_ctrl_reg.sv
module sertx_ctrl_reg
    import sertx_pkg::*;
#(
    parameter int ADDR_W   = 3,
    parameter int CFG_OFS  = 3,
    parameter int HOLD_OFS = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    output line_cfg_t         cfg,
    output logic              load_req
);

    line_cfg_t cfg_q;
    logic      cfg_sel;
    logic      hold_sel;

    assign cfg_sel  = (addr == ADDR_W'(CFG_OFS));
    assign hold_sel = (addr == ADDR_W'(HOLD_OFS));

    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= '0;
        else if (wr_en && cfg_sel)
            cfg_q <= line_cfg_t'(wdata);
    end

    assign cfg      = cfg_q;
    assign load_req = wr_en && hold_sel && !cfg_q.dlab;
    assign rdata    = (rd_en && cfg_sel) ? BYTE_W'(cfg_q) : '0;

    assert_cfg_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && cfg_sel) |=> $stable(cfg_q));

endmodule

// File: rtl/sertx_framer.sv
module sertx_framer
    import sertx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              load_req,
    input  logic [BYTE_W-1:0] load_data,
    input  line_cfg_t         cfg,
    output logic              line_bit,
    output logic              busy
);

    tx_state_t         state;
    logic [CNT_W-1:0]  cnt;
    logic [IDX_W-1:0]  idx;
    logic [BYTE_W-1:0] shreg;
    line_cfg_t         fmt;
    logic              par_q;
    logic              bit_end;

    assign bit_end = tick && (cnt == CNT_W'(TICKS_PER_BIT - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
            idx   <= '0;
            shreg <= '0;
            fmt   <= '0;
            par_q <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (load_req) begin
                        state <= ST_START;
                        cnt   <= '0;
                        idx   <= '0;
                        shreg <= load_data;
                        fmt   <= cfg;
                        par_q <= parity_value(cfg, load_data);
                    end
                end
                ST_START: begin
                    if (bit_end) begin
                        cnt   <= '0;
                        state <= ST_DATA;
                    end else if (tick) begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_DATA: begin
                    if (bit_end) begin
                        cnt   <= '0;
                        shreg <= shreg >> 1;
                        if (idx == last_bit_index(fmt.wlen))
                            state <= fmt.par_en ? ST_PAR : ST_STOP;
                        else
                            idx <= idx + 1'b1;
                    end else if (tick) begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_PAR: begin
                    if (bit_end) begin
                        cnt   <= '0;
                        state <= ST_STOP;
                    end else if (tick) begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_STOP: begin
                    if (tick && cnt == stop_last_count(fmt)) begin
                        cnt   <= '0;
                        state <= ST_IDLE;
                    end else if (tick) begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        unique case (state)
            ST_START: line_bit = 1'b0;
            ST_DATA:  line_bit = shreg[0];
            ST_PAR:   line_bit = par_q;
            default:  line_bit = 1'b1;
        endcase
    end

    assign busy = (state != ST_IDLE);

    assert_load_busy_R9: assert property (@(posedge clk) disable iff (rst)
        (load_req && !busy) |=> busy);

    assert_start_low_R1: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !line_bit);

    assert_bit_count_R1: assert property (@(posedge clk) disable iff (rst)
        (state != ST_STOP) |-> (cnt <= CNT_W'(TICKS_PER_BIT - 1)));

    assert_data_index_R1: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DATA) |-> (idx <= last_bit_index(fmt.wlen)));

    assert_stop_bound_R3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_STOP) |-> (cnt <= stop_last_count(fmt)));

endmodule

// File: rtl/sertx_top.sv
module sertx_top
    import sertx_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    input  logic              tick,
    output logic              txd,
    output logic              busy
);

    line_cfg_t cfg;
    logic      load_req;
    logic      line_bit;

    sertx_ctrl_reg #(
        .ADDR_W  (ADDR_W),
        .CFG_OFS (3),
        .HOLD_OFS(0)
    ) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .addr    (addr),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .wdata   (wdata),
        .rdata   (rdata),
        .cfg     (cfg),
        .load_req(load_req)
    );

    sertx_framer u_framer (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .load_req (load_req),
        .load_data(wdata),
        .cfg      (cfg),
        .line_bit (line_bit),
        .busy     (busy)
    );

    assign txd = cfg.brk ? 1'b0 : line_bit;

    assert_idle_line_R10: assert property (@(posedge clk) disable iff (rst)
        (!busy && !cfg.brk) |-> txd);

endmodule

// File: tb/sertx_top_test.sv
`timescale 1ns/1ps
module sertx_top_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] addr = '0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       tick = 1'b0;
    logic       txd;
    logic       busy;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    sertx_top uut (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .tick(tick), .txd(txd), .busy(busy)
    );

    // {configuration byte, data byte}
    localparam logic [15:0] VEC [8] = '{
        {8'h03, 8'hA5},
        {8'h00, 8'h15},
        {8'h04, 8'h0B},
        {8'h05, 8'h2C},
        {8'h1B, 8'h6E},
        {8'h0A, 8'h55},
        {8'h2B, 8'hF0},
        {8'h3E, 8'h7F}
    };

    task automatic check(input bit cond, input string req, input int act, input int exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 d = rdata;
        rd_en = 1'b0;
    endtask

    task automatic tick_once(output logic got, output logic b);
        @(negedge clk);
        tick = 1'b1;
        got = txd;
        b = busy;
        @(negedge clk);
        tick = 1'b0;
    endtask

    function automatic string tag_of(input logic [7:0] c);
        if (c[3] && c[5]) return "R6";
        if (c[3])         return "R5";
        if (!c[2])        return "R2";
        if (c[1:0] == 0)  return "R3";
        return "R4";
    endfunction

    task automatic run_frame(input logic [7:0] c, input logic [7:0] d);
        logic exp_v[0:255];
        int   nb, stop_t, t, mism, first_t;
        logic ones, par, got, b, bsy_ok;
        string tag;
        tag = tag_of(c);
        nb = 5 + int'(c[1:0]);
        stop_t = !c[2] ? 16 : (c[1:0] == 2'b00 ? 24 : 32);
        ones = 1'b0;
        for (int i = 0; i < nb; i++) ones ^= d[i];
        par = c[5] ? ~c[4] : (c[4] ? ones : ~ones);
        t = 0;
        for (int k = 0; k < 16; k++) begin exp_v[t] = 1'b0; t = t + 1; end
        for (int i = 0; i < nb; i++)
            for (int k = 0; k < 16; k++) begin exp_v[t] = d[i]; t = t + 1; end
        if (c[3])
            for (int k = 0; k < 16; k++) begin exp_v[t] = par; t = t + 1; end
        for (int k = 0; k < stop_t; k++) begin exp_v[t] = 1'b1; t = t + 1; end
        bus_wr(3'd3, c);
        bus_wr(3'd0, d);
        mism = 0; first_t = 0; bsy_ok = 1'b1;
        for (int j = 0; j < t; j++) begin
            tick_once(got, b);
            if (got !== exp_v[j]) begin
                if (mism == 0) first_t = j;
                mism++;
            end
            if (b !== 1'b1) bsy_ok = 1'b0;
        end
        check(mism == 0, {"R1 ", tag, " waveform mismatches (first tick in actual)"},
              mism == 0 ? 0 : first_t, 0);
        check(bsy_ok, "R9 busy high through frame", bsy_ok, 1);
        check(busy === 1'b0 && txd === 1'b1, {"R9 ", tag, " idle after stop"},
              {busy, txd}, 2'b01);
    endtask

    initial begin
        logic [7:0] rd;
        logic       got, b;
        int         n, hi, lowcnt;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(txd === 1'b1 && busy === 1'b0, "R10 reset outputs", {busy, txd}, 2'b01);
        bus_rd(3'd3, rd);
        check(rd === 8'h00, "R10 reset configuration", rd, 8'h00);

        // R8 readback
        bus_wr(3'd3, 8'hC7);
        bus_rd(3'd3, rd);
        check(rd === 8'hC7, "R8 readback", rd, 8'hC7);
        bus_rd(3'd1, rd);
        check(rd === 8'h00, "R8 other offset", rd, 8'h00);
        addr = 3'd3;
        #1 check(rdata === 8'h00, "R8 no read strobe", rdata, 8'h00);

        // R9 data write ignored while bit 7 set
        bus_wr(3'd3, 8'h83);
        bus_wr(3'd0, 8'h55);
        check(busy === 1'b0 && txd === 1'b1, "R9 write ignored with bit 7", {busy, txd}, 2'b01);
        tick_once(got, b);
        check(b === 1'b0 && got === 1'b1, "R9 still idle with bit 7", {b, got}, 2'b01);

        // vector table
        for (int v = 0; v < 8; v++) run_frame(VEC[v][15:8], VEC[v][7:0]);

        // R9 write during a frame is ignored
        bus_wr(3'd3, 8'h03);
        bus_wr(3'd0, 8'h00);
        for (int k = 0; k < 20; k++) tick_once(got, b);
        bus_wr(3'd0, 8'hFF);
        n = 20; hi = 0;
        while (busy && n < 400) begin
            tick_once(got, b);
            n++;
            if (got) hi++;
        end
        check(n == 160, "R9 frame length with write while busy", n, 160);
        check(hi == 16, "R9 data unchanged by write while busy", hi, 16);

        // R7 break forcing mid-frame
        bus_wr(3'd0, 8'hFF);
        for (int k = 0; k < 20; k++) tick_once(got, b);
        bus_wr(3'd3, 8'h43);
        lowcnt = 0;
        for (int k = 0; k < 20; k++) begin
            tick_once(got, b);
            if (got === 1'b0 && b === 1'b1) lowcnt++;
        end
        check(lowcnt == 20, "R7 line low and busy during break", lowcnt, 20);
        bus_wr(3'd3, 8'h03);
        n = 40;
        while (busy && n < 400) begin
            tick_once(got, b);
            n++;
        end
        check(n == 160, "R7 frame timing kept through break", n, 160);
        check(txd === 1'b1, "R7 line released after break", txd, 1);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #3000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule